// File: doc/BRIEF.md
# Instruction-Side Shadow Translation Buffer with Deferred Sync

This block keeps a small, fully associative copy of instruction translations taken from a larger unified translation buffer that lives outside it. Every fetch address is looked up in the same cycle. When instruction translation is off, the address passes through unchanged. When translation is on, a matching entry supplies the real page number, and a miss raises a refill request. The request holds the fetch until the outside buffer returns the missing entry.

Software writes to the unified buffer, the process ID, the zone protection word and the translate-enable bits are only recorded as pending. The lookup path keeps using its active copy of that state. An active copy changes only at a context-synchronizing event: interrupt entry, return from interrupt, or an explicit instruction sync. Each of these events discards every shadow entry. Interrupt entry also switches both translations off, so the handler fetches in real mode.

Top module: `shadow_itlb`

## Requirements
- R1: After reset, all shadow entries are invalid, `xlate_on`, `data_xlate_on` and `sync_pending` are 0, and the active process ID and zone word are 0.
- R2: While `xlate_on` is 0, a fetch reports `fetch_hit`=1 with `fetch_ra` equal to `fetch_ea`, and `refill_req` and `fetch_fault` stay 0.
- R3: While `xlate_on` is 1, an entry matches when it is valid, its tag equals `fetch_ea[31:12]`, and its process ID equals the active one or is 0 (global). A match gives `fetch_hit`=1 and `fetch_ra` = {entry page, `fetch_ea[11:0]`}.
- R4: A translated fetch with no match gives `fetch_hit`=0 and `refill_req`=1, with `refill_vpn`=`fetch_ea[31:12]` and `refill_pid` equal to the active process ID. This holds until `refill_valid` is seen. The entry then holds the fetch tag together with the returned page, process ID and zone, and the same fetch hits on the next cycle.
- R5: There are four entries. Refills fill them round-robin, starting from slot 0 after each sync event, so the fifth refill replaces the first entry.
- R6: `pid_wr`, `zpr_wr`, `msr_wr` and `utlb_wr` do not change any lookup result or active state until a sync event. Any one of them sets `sync_pending` to 1 on the next cycle.
- R7: `rfi` or `isync` invalidates every entry and copies the pending process ID, zone word and enable bits into the active copies, including writes in that same cycle. The effect shows on the next cycle, and `sync_pending` returns to 0.
- R8: `irq_entry` invalidates every entry and clears both the active and the pending enable bits. It takes priority over `rfi` or `isync` asserted in the same cycle.
- R9: On a translated hit with `fetch_user`=1, `fetch_fault` is 1 when the two-bit active zone code for the entry's zone z (bits [2z+1:2z] of the zone word) is 00. Otherwise it is 0, and it is always 0 in supervisor mode.
- R10: A `refill_valid` that arrives in the same cycle as any sync event is dropped, so no entry becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch lookup valid |
| fetch_ea | input | 32 | Fetch effective address |
| fetch_user | input | 1 | Fetch runs in problem (user) state |
| fetch_hit | output | 1 | Translation available this cycle |
| fetch_fault | output | 1 | Zone protection denies the fetch |
| fetch_ra | output | 32 | Real address |
| refill_req | output | 1 | Miss, entry requested from unified buffer |
| refill_vpn | output | 20 | Page number being requested |
| refill_pid | output | 8 | Active process ID of the request |
| refill_valid | input | 1 | Refill response strobe |
| refill_rpn | input | 20 | Returned real page number |
| refill_rpid | input | 8 | Returned entry process ID (0 = global) |
| refill_zone | input | 4 | Returned entry zone |
| utlb_wr | input | 1 | Unified buffer was written |
| pid_wr | input | 1 | Process ID write strobe |
| pid_in | input | 8 | New process ID |
| zpr_wr | input | 1 | Zone word write strobe |
| zpr_in | input | 32 | New zone word |
| msr_wr | input | 1 | Enable-bit write strobe |
| msr_ir | input | 1 | New instruction translate enable |
| msr_dr | input | 1 | New data translate enable |
| irq_entry | input | 1 | Interrupt entry strobe |
| rfi | input | 1 | Return-from-interrupt strobe |
| isync | input | 1 | Instruction sync strobe |
| xlate_on | output | 1 | Active instruction translate enable |
| data_xlate_on | output | 1 | Active data translate enable |
| sync_pending | output | 1 | Pending updates not yet synchronized |

## Verification
Two pairs of functions can land in the same cycle. A refill response can arrive together with a sync strobe, and interrupt entry can be raised together with return-from-interrupt. The bench drives `refill_valid` and `isync` in the same cycle during an outstanding miss and judges the result from the port: the fetch must still miss on the following cycle. It also raises `irq_entry` and `rfi` together while translation is pending-enabled, then expects real-mode pass-through both right after that cycle and after a later lone `rfi`.

// File: rtl/shadow_itlb.sv
module shadow_itlb #(
  parameter int EA_W  = 32,
  parameter int PG_SH = 12,
  parameter int PID_W = 8,
  parameter int ZONES = 16,
  parameter int NENT  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_req,
  input  logic [EA_W-1:0]       fetch_ea,
  input  logic                  fetch_user,
  output logic                  fetch_hit,
  output logic                  fetch_fault,
  output logic [EA_W-1:0]       fetch_ra,
  output logic                  refill_req,
  output logic [EA_W-PG_SH-1:0] refill_vpn,
  output logic [PID_W-1:0]      refill_pid,
  input  logic                  refill_valid,
  input  logic [EA_W-PG_SH-1:0] refill_rpn,
  input  logic [PID_W-1:0]      refill_rpid,
  input  logic [$clog2(ZONES)-1:0] refill_zone,
  input  logic                  utlb_wr,
  input  logic                  pid_wr,
  input  logic [PID_W-1:0]      pid_in,
  input  logic                  zpr_wr,
  input  logic [2*ZONES-1:0]    zpr_in,
  input  logic                  msr_wr,
  input  logic                  msr_ir,
  input  logic                  msr_dr,
  input  logic                  irq_entry,
  input  logic                  rfi,
  input  logic                  isync,
  output logic                  xlate_on,
  output logic                  data_xlate_on,
  output logic                  sync_pending
);
  localparam int VPN_W = EA_W - PG_SH;
  localparam int ZN_W  = $clog2(ZONES);
  localparam int IDX_W = $clog2(NENT);

  logic [VPN_W-1:0] e_tag  [NENT];
  logic [VPN_W-1:0] e_rpn  [NENT];
  logic [PID_W-1:0] e_pid  [NENT];
  logic [ZN_W-1:0]  e_zone [NENT];
  logic [NENT-1:0]  e_vld;
  logic [NENT-1:0]  match;

  logic [PID_W-1:0]   act_pid, pnd_pid, nxt_pid;
  logic [2*ZONES-1:0] act_zpr, pnd_zpr, nxt_zpr;
  logic               act_ir, act_dr, pnd_ir, pnd_dr, nxt_ir, nxt_dr;
  logic [IDX_W-1:0]   rr;
  logic               pend_flag;

  logic [VPN_W-1:0] ea_vpn;
  logic             any_hit;
  logic [VPN_W-1:0] hit_rpn;
  logic [ZN_W-1:0]  hit_zone;
  logic [1:0]       hit_code;
  logic             sync_any, commit, refill_ok;

  assign ea_vpn = fetch_ea[EA_W-1:PG_SH];

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign match[g] = e_vld[g] && (e_tag[g] == ea_vpn) &&
                      ((e_pid[g] == act_pid) || (e_pid[g] == '0));
  end

  always_comb begin
    hit_rpn  = '0;
    hit_zone = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_rpn  = e_rpn[i];
        hit_zone = e_zone[i];
      end
    end
  end

  assign any_hit  = |match;
  assign hit_code = act_zpr[2*hit_zone +: 2];

  assign fetch_hit   = fetch_req && (!act_ir || any_hit);
  assign fetch_ra    = act_ir ? {hit_rpn, fetch_ea[PG_SH-1:0]} : fetch_ea;
  assign fetch_fault = fetch_req && act_ir && any_hit && fetch_user && (hit_code == 2'b00);
  assign refill_req  = fetch_req && act_ir && !any_hit;
  assign refill_vpn  = ea_vpn;
  assign refill_pid  = act_pid;

  assign nxt_pid = pid_wr ? pid_in : pnd_pid;
  assign nxt_zpr = zpr_wr ? zpr_in : pnd_zpr;
  assign nxt_ir  = msr_wr ? msr_ir : pnd_ir;
  assign nxt_dr  = msr_wr ? msr_dr : pnd_dr;

  assign commit    = rfi || isync;
  assign sync_any  = irq_entry || commit;
  assign refill_ok = refill_valid && refill_req && !sync_any;

  assign xlate_on      = act_ir;
  assign data_xlate_on = act_dr;
  assign sync_pending  = pend_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld     <= '0;
      act_pid   <= '0;
      act_zpr   <= '0;
      act_ir    <= 1'b0;
      act_dr    <= 1'b0;
      pnd_pid   <= '0;
      pnd_zpr   <= '0;
      pnd_ir    <= 1'b0;
      pnd_dr    <= 1'b0;
      rr        <= '0;
      pend_flag <= 1'b0;
    end else begin
      pnd_pid <= nxt_pid;
      pnd_zpr <= nxt_zpr;
      pnd_ir  <= nxt_ir;
      pnd_dr  <= nxt_dr;
      if (pid_wr || zpr_wr || msr_wr || utlb_wr) pend_flag <= 1'b1;
      if (irq_entry) begin
        e_vld     <= '0;
        rr        <= '0;
        pnd_ir    <= 1'b0;
        pnd_dr    <= 1'b0;
        act_ir    <= 1'b0;
        act_dr    <= 1'b0;
        act_pid   <= nxt_pid;
        act_zpr   <= nxt_zpr;
        pend_flag <= 1'b0;
      end else if (commit) begin
        e_vld     <= '0;
        rr        <= '0;
        act_ir    <= nxt_ir;
        act_dr    <= nxt_dr;
        act_pid   <= nxt_pid;
        act_zpr   <= nxt_zpr;
        pend_flag <= 1'b0;
      end else if (refill_ok) begin
        e_vld[rr] <= 1'b1;
        rr        <= rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (refill_ok) begin
      e_tag[rr]  <= ea_vpn;
      e_rpn[rr]  <= refill_rpn;
      e_pid[rr]  <= refill_rpid;
      e_zone[rr] <= refill_zone;
    end
  end

  assert_real_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !xlate_on) |-> (fetch_hit && fetch_ra == fetch_ea && !refill_req && !fetch_fault));

  assert_refill_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && refill_valid && !sync_any) |=> (e_vld[$past(rr)] && rr == $past(rr) + 1'b1));

  assert_hold_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_any |=> ($stable(xlate_on) && $stable(act_pid) && $stable(act_zpr) && $stable(data_xlate_on)));

  assert_sync_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (e_vld == '0 && !sync_pending));

  assert_irq_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> (!xlate_on && !data_xlate_on && e_vld == '0));

  assert_fault_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> (fetch_hit && fetch_user && xlate_on));

  assert_drop_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_any && refill_valid) |=> ($countones(e_vld) == 0));
endmodule

// File: tb/shadow_itlb_tb.sv
module shadow_itlb_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic fetch_req = 0, fetch_user = 0;
  logic [31:0] fetch_ea = '0;
  logic fetch_hit, fetch_fault, refill_req;
  logic [31:0] fetch_ra;
  logic [19:0] refill_vpn;
  logic [7:0]  refill_pid;
  logic refill_valid = 0;
  logic [19:0] refill_rpn = '0;
  logic [7:0]  refill_rpid = '0;
  logic [3:0]  refill_zone = '0;
  logic utlb_wr = 0, pid_wr = 0, zpr_wr = 0, msr_wr = 0, msr_ir = 0, msr_dr = 0;
  logic [7:0]  pid_in = '0;
  logic [31:0] zpr_in = '0;
  logic irq_entry = 0, rfi = 0, isync = 0;
  logic xlate_on, data_xlate_on, sync_pending;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_itlb dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ea(fetch_ea),
    .fetch_user(fetch_user), .fetch_hit(fetch_hit), .fetch_fault(fetch_fault),
    .fetch_ra(fetch_ra), .refill_req(refill_req), .refill_vpn(refill_vpn),
    .refill_pid(refill_pid), .refill_valid(refill_valid), .refill_rpn(refill_rpn),
    .refill_rpid(refill_rpid), .refill_zone(refill_zone), .utlb_wr(utlb_wr),
    .pid_wr(pid_wr), .pid_in(pid_in), .zpr_wr(zpr_wr), .zpr_in(zpr_in),
    .msr_wr(msr_wr), .msr_ir(msr_ir), .msr_dr(msr_dr), .irq_entry(irq_entry),
    .rfi(rfi), .isync(isync), .xlate_on(xlate_on), .data_xlate_on(data_xlate_on),
    .sync_pending(sync_pending));

  localparam logic [31:0] EA_A = 32'h0001_2345;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic refill(input logic [19:0] rpn, input logic [7:0] pid, input logic [3:0] zn);
    refill_valid = 1; refill_rpn = rpn; refill_rpid = pid; refill_zone = zn;
    cyc();
    refill_valid = 0;
    #1;
  endtask

  task automatic sync_now();
    isync = 1;
    cyc();
    isync = 0;
    #1;
  endtask

  task automatic t_reset();
    fetch_req = 1; fetch_ea = EA_A; #1;
    chk(xlate_on == 0 && data_xlate_on == 0, "R1", "translate enables", {30'b0, xlate_on, data_xlate_on}, 0);
    chk(sync_pending == 0, "R1", "sync_pending", sync_pending, 0);
    chk(refill_pid == 0, "R1", "active pid", refill_pid, 0);
    chk(fetch_hit && fetch_ra == EA_A, "R2", "real mode ra", fetch_ra, EA_A);
    chk(!refill_req && !fetch_fault, "R2", "no refill/fault", {30'b0, refill_req, fetch_fault}, 0);
  endtask

  task automatic t_enable_and_refill();
    msr_wr = 1; msr_ir = 1; msr_dr = 1;
    cyc();
    msr_wr = 0; #1;
    chk(xlate_on == 0 && fetch_ra == EA_A, "R6", "msr write before sync", fetch_ra, EA_A);
    chk(sync_pending == 1, "R6", "sync_pending set", sync_pending, 1);
    sync_now();
    chk(xlate_on && data_xlate_on && !sync_pending, "R7", "enables latched", {29'b0, xlate_on, data_xlate_on, sync_pending}, 6);
    chk(!fetch_hit && refill_req, "R4", "miss raises refill", {30'b0, fetch_hit, refill_req}, 1);
    chk(refill_vpn == 20'h00012, "R4", "refill vpn", refill_vpn, 20'h00012);
    refill(20'h80000, 8'd0, 4'd1);
    chk(fetch_hit && !refill_req, "R4", "hit after refill", {30'b0, fetch_hit, refill_req}, 2);
    chk(fetch_ra == 32'h8000_0345, "R3", "translated ra", fetch_ra, 32'h8000_0345);
  endtask

  task automatic t_pid();
    pid_wr = 1; pid_in = 8'd5;
    cyc();
    pid_wr = 0; #1;
    chk(fetch_hit && refill_pid == 0, "R6", "pid pending only", refill_pid, 0);
    rfi = 1; cyc(); rfi = 0; #1;
    chk(refill_req && refill_pid == 8'd5, "R7", "rfi invalidates, pid 5", refill_pid, 5);
    refill(20'h80007, 8'd7, 4'd1);
    chk(refill_req && !fetch_hit, "R3", "foreign pid misses", fetch_hit, 0);
    refill(20'h80001, 8'd5, 4'd1);
    chk(fetch_hit && fetch_ra == 32'h8000_1345, "R3", "own pid hits", fetch_ra, 32'h8000_1345);
  endtask

  task automatic t_utlb_write();
    utlb_wr = 1;
    cyc();
    utlb_wr = 0; #1;
    chk(fetch_hit && fetch_ra == 32'h8000_1345, "R6", "utlb write w/o sync keeps result", fetch_ra, 32'h8000_1345);
    chk(sync_pending == 1, "R6", "utlb write pending", sync_pending, 1);
    sync_now();
    chk(refill_req && !fetch_hit, "R7", "sync drops old translation", fetch_hit, 0);
    refill(20'h90000, 8'd5, 4'd1);
    chk(fetch_ra == 32'h9000_0345, "R7", "new translation after sync", fetch_ra, 32'h9000_0345);
  endtask

  task automatic t_round_robin();
    sync_now();
    for (int i = 1; i <= 5; i++) begin
      fetch_ea = (i << 12) | 32'h10; #1;
      chk(refill_req, "R5", "fresh page misses", refill_req, 1);
      refill(20'h100 + i, 8'd0, 4'd1);
    end
    fetch_ea = 32'h0000_1010; #1;
    chk(refill_req && !fetch_hit, "R5", "oldest replaced", fetch_hit, 0);
    fetch_ea = 32'h0000_2010; #1;
    chk(fetch_hit && fetch_ra == 32'h0010_2010, "R5", "second kept", fetch_ra, 32'h0010_2010);
    fetch_ea = 32'h0000_5010; #1;
    chk(fetch_hit && fetch_ra == 32'h0010_5010, "R5", "fifth in slot 0", fetch_ra, 32'h0010_5010);
  endtask

  task automatic t_zone();
    fetch_ea = EA_A; fetch_user = 1;
    zpr_wr = 1; zpr_in = 32'h0000_0004;
    sync_now();
    zpr_wr = 0; #1;
    refill(20'h80000, 8'd0, 4'd1);
    chk(fetch_hit && !fetch_fault, "R9", "zone code 01 allows", fetch_fault, 0);
    zpr_wr = 1; zpr_in = 32'h0;
    cyc();
    zpr_wr = 0; #1;
    chk(!fetch_fault, "R6", "zone write w/o sync", fetch_fault, 0);
    sync_now();
    refill(20'h80000, 8'd0, 4'd1);
    chk(fetch_hit && fetch_fault, "R9", "zone code 00 faults user", fetch_fault, 1);
    fetch_user = 0; #1;
    chk(!fetch_fault, "R9", "supervisor no fault", fetch_fault, 0);
  endtask

  task automatic t_refill_vs_sync();
    chk(refill_req == 0, "R10", "precondition hit", refill_req, 0);
    fetch_ea = 32'h0007_7000; #1;
    refill_valid = 1; refill_rpn = 20'hABCDE; isync = 1;
    cyc();
    refill_valid = 0; isync = 0; #1;
    chk(refill_req && !fetch_hit, "R10", "refill with sync dropped", fetch_hit, 0);
  endtask

  task automatic t_irq();
    irq_entry = 1; rfi = 1;
    cyc();
    irq_entry = 0; rfi = 0; #1;
    chk(!xlate_on && !data_xlate_on, "R8", "irq wins over rfi", {30'b0, xlate_on, data_xlate_on}, 0);
    chk(fetch_hit && fetch_ra == 32'h0007_7000, "R8", "real mode in handler", fetch_ra, 32'h0007_7000);
    rfi = 1; cyc(); rfi = 0; #1;
    chk(!xlate_on, "R8", "pending enable cleared", xlate_on, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_enable_and_refill();
    t_pid();
    t_utlb_write();
    t_round_robin();
    t_zone();
    t_refill_vs_sync();
    t_irq();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule